// File: doc/BRIEF.md
# Privilege-Masked Authority Register File

This block holds two 64-bit special-purpose registers for a processor core: an authority mask, whose bit pairs a downstream page-permission checker reads to grant or withhold read and write rights, and a user-modify mask, which limits what unprivileged code may change in the authority mask. Software reaches both registers through a single-port register access interface. Each access presents a register number, read and write strobes, write data, and a flag that is high while the core runs in user (unprivileged) mode.

The authority mask answers at two register numbers. The user alias (13) may be used from either mode. The privileged alias (29) may be used only from privileged mode. The user-modify mask sits at number 0x9D and is also reserved to privileged mode. When user-mode code writes through the user alias, the register stores the write data ANDed with the user-modify mask. Bits that the mask does not grant are therefore cleared, not kept. A privileged write through either alias stores the whole word. If user-mode code touches a privileged-only number, the block flags an illegal access and changes nothing. The trap that follows is left to the core.

Read data and the illegal flag are registered. Both appear in the cycle after the access strobe. The stored authority mask drives a dedicated output without interruption.

Top module: `authmask_regfile`

## Requirements
- R1: A read of number 13 returns the stored authority mask on `rd_data_o` in the cycle after the strobe, in user mode and in privileged mode alike.
- R2: A privileged read of number 29 returns the stored authority mask, and a privileged read of number 0x9D returns the user-modify mask, in the cycle after the strobe.
- R3: A user-mode write to number 13 stores (write data AND user-modify mask) into the authority mask. Bits where the mask is 0 become 0.
- R4: A privileged write to number 13 or number 29 stores the full 64-bit write data into the authority mask.
- R5: A privileged write to number 0x9D stores the full write data into the user-modify mask.
- R6: After reset the authority mask is all ones (0xFFFF_FFFF_FFFF_FFFF), the user-modify mask is zero, and `illegal_o` and `rd_data_o` are zero.
- R7: A user-mode read or write of number 29 or 0x9D drives `illegal_o` high for exactly the one cycle after the strobe. It returns zero read data and leaves both registers unchanged.
- R8: A write becomes visible on the clock edge that ends its strobe cycle. A read strobed in the same cycle as a write to the same register returns the value from before the write.
- R9: An access to any other register number returns zero read data, does not raise `illegal_o`, and changes neither register. `rd_data_o` is zero in any cycle that does not follow a legal read.
- R10: `auth_mask_o` always presents the stored authority mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spr_num_i | input | 10 | Register number of the access |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 64 | Write data |
| user_mode_i | input | 1 | High when the access comes from user mode |
| rd_data_o | output | 64 | Registered read data, valid the cycle after a read strobe |
| illegal_o | output | 1 | One-cycle pulse flagging a privilege violation |
| auth_mask_o | output | 64 | Current authority mask for the permission checker |

## Verification
The assertions assume that the strobes, the register number, the mode flag and the write data are known, stable values at every clock edge once reset has been released. They also assume that reset is held for at least one edge before any access is made. The bench drives every input only on the falling clock edge and holds it for a whole cycle. It starts its accesses after reset has been released for several cycles. It always leaves the strobes at zero between accesses, so no strobe ever carries an unknown value.

// File: rtl/authmask_pkg.sv
package authmask_pkg;
  localparam int XLEN  = 64;
  localparam int SPR_W = 10;

  typedef enum logic [1:0] {
    SEL_NONE     = 2'd0,
    SEL_AUTH_USR = 2'd1,
    SEL_AUTH_PRV = 2'd2,
    SEL_UMASK    = 2'd3
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e sel;
    logic     legal;
    logic     illegal;
  } access_t;
endpackage

// File: rtl/authmask_decode.sv
module authmask_decode
  import authmask_pkg::*;
#(
  parameter int                NUM_W     = SPR_W,
  parameter logic [NUM_W-1:0]  NUM_AUSR  = 13,
  parameter logic [NUM_W-1:0]  NUM_APRV  = 29,
  parameter logic [NUM_W-1:0]  NUM_UMASK = 'h9D
) (
  input  logic [NUM_W-1:0] num_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             user_i,
  output access_t          acc_o
);
  logic active;
  logic hit_usr, hit_prv, hit_msk;

  always_comb begin
    active  = rd_i | wr_i;
    hit_usr = (num_i == NUM_AUSR);
    hit_prv = (num_i == NUM_APRV);
    hit_msk = (num_i == NUM_UMASK);

    acc_o.sel = SEL_NONE;
    if (hit_usr)      acc_o.sel = SEL_AUTH_USR;
    else if (hit_prv) acc_o.sel = SEL_AUTH_PRV;
    else if (hit_msk) acc_o.sel = SEL_UMASK;

    acc_o.illegal = active & user_i & (hit_prv | hit_msk);
    acc_o.legal   = active & (hit_usr | ((hit_prv | hit_msk) & ~user_i));
  end
endmodule

// File: rtl/authmask_store.sv
module authmask_store
  import authmask_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic         user_i,
  input  access_t      acc_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] auth_q,
  output logic [W-1:0] umask_q
);
  localparam logic [W-1:0] AUTH_RST  = '1;
  localparam logic [W-1:0] UMASK_RST = '0;

  logic         wr_auth, wr_umask, filter;
  logic [W-1:0] auth_d;

  always_comb begin
    wr_auth  = wr_i & acc_i.legal &
               ((acc_i.sel == SEL_AUTH_USR) | (acc_i.sel == SEL_AUTH_PRV));
    wr_umask = wr_i & acc_i.legal & (acc_i.sel == SEL_UMASK);
    filter   = user_i & (acc_i.sel == SEL_AUTH_USR);
  end

  // Per-bit write path: a filtered write keeps only the granted bits.
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb auth_d[b] = filter ? (wdata_i[b] & umask_q[b]) : wdata_i[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      auth_q  <= AUTH_RST;
      umask_q <= UMASK_RST;
    end else begin
      if (wr_auth)  auth_q  <= auth_d;
      if (wr_umask) umask_q <= wdata_i;
    end
  end
endmodule

// File: rtl/authmask_readout.sv
module authmask_readout
  import authmask_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_i,
  input  access_t      acc_i,
  input  logic [W-1:0] auth_i,
  input  logic [W-1:0] umask_i,
  output logic [W-1:0] rd_data_o,
  output logic         illegal_o
);
  logic [W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (rd_i && acc_i.legal) begin
      unique case (acc_i.sel)
        SEL_AUTH_USR, SEL_AUTH_PRV: rd_d = auth_i;
        SEL_UMASK:                  rd_d = umask_i;
        default:                    rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
      illegal_o <= 1'b0;
    end else begin
      rd_data_o <= rd_d;
      illegal_o <= acc_i.illegal;
    end
  end
endmodule

// File: rtl/authmask_regfile.sv
module authmask_regfile
  import authmask_pkg::*;
#(
  parameter int                W         = XLEN,
  parameter int                NUM_W     = SPR_W,
  parameter logic [NUM_W-1:0]  NUM_AUSR  = 13,
  parameter logic [NUM_W-1:0]  NUM_APRV  = 29,
  parameter logic [NUM_W-1:0]  NUM_UMASK = 'h9D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM_W-1:0] spr_num_i,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             user_mode_i,
  output logic [W-1:0]     rd_data_o,
  output logic             illegal_o,
  output logic [W-1:0]     auth_mask_o
);
  access_t      acc;
  logic [W-1:0] auth_q, umask_q;

  authmask_decode #(
    .NUM_W(NUM_W), .NUM_AUSR(NUM_AUSR), .NUM_APRV(NUM_APRV), .NUM_UMASK(NUM_UMASK)
  ) u_decode (
    .num_i (spr_num_i),
    .rd_i  (rd_en_i),
    .wr_i  (wr_en_i),
    .user_i(user_mode_i),
    .acc_o (acc)
  );

  authmask_store #(.W(W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (wr_en_i),
    .user_i (user_mode_i),
    .acc_i  (acc),
    .wdata_i(wr_data_i),
    .auth_q (auth_q),
    .umask_q(umask_q)
  );

  authmask_readout #(.W(W)) u_readout (
    .clk      (clk),
    .rst      (rst),
    .rd_i     (rd_en_i),
    .acc_i    (acc),
    .auth_i   (auth_q),
    .umask_i  (umask_q),
    .rd_data_o(rd_data_o),
    .illegal_o(illegal_o)
  );

  assign auth_mask_o = auth_q;
endmodule

// File: rtl/authmask_checker.sv
module authmask_checker #(
  parameter int                W         = 64,
  parameter int                NUM_W     = 10,
  parameter logic [NUM_W-1:0]  NUM_AUSR  = 13,
  parameter logic [NUM_W-1:0]  NUM_APRV  = 29,
  parameter logic [NUM_W-1:0]  NUM_UMASK = 'h9D
) (
  input logic             clk,
  input logic             rst,
  input logic [NUM_W-1:0] spr_num_i,
  input logic             rd_en_i,
  input logic             wr_en_i,
  input logic [W-1:0]     wr_data_i,
  input logic             user_mode_i,
  input logic [W-1:0]     rd_data_o,
  input logic             illegal_o,
  input logic [W-1:0]     auth_mask_o,
  input logic [W-1:0]     umask_q
);
  logic blocked;
  assign blocked = (rd_en_i | wr_en_i) & user_mode_i &
                   ((spr_num_i == NUM_APRV) | (spr_num_i == NUM_UMASK));

  // R6
  p_reset_state_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (auth_mask_o == '1) && (umask_q == '0) && !illegal_o);

  // R3
  p_user_write_masked_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && user_mode_i && spr_num_i == NUM_AUSR)
      |=> auth_mask_o == ($past(wr_data_i) & $past(umask_q)));

  // R4
  p_priv_write_full_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !user_mode_i && (spr_num_i == NUM_AUSR || spr_num_i == NUM_APRV))
      |=> auth_mask_o == $past(wr_data_i));

  // R7
  p_illegal_flag_r7: assert property (@(posedge clk) disable iff (rst)
    blocked |=> illegal_o && rd_data_o == '0);

  // R7
  p_illegal_no_change_r7: assert property (@(posedge clk) disable iff (rst)
    blocked |=> $stable(auth_mask_o) && $stable(umask_q));

  // R7
  p_illegal_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    !blocked |=> !illegal_o);

  // R8
  p_read_old_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && wr_en_i && !user_mode_i && spr_num_i == NUM_APRV)
      |=> rd_data_o == $past(auth_mask_o));
endmodule

bind authmask_regfile authmask_checker #(
  .W(W), .NUM_W(NUM_W), .NUM_AUSR(NUM_AUSR), .NUM_APRV(NUM_APRV), .NUM_UMASK(NUM_UMASK)
) i_authmask_checker (
  .clk        (clk),
  .rst        (rst),
  .spr_num_i  (spr_num_i),
  .rd_en_i    (rd_en_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .user_mode_i(user_mode_i),
  .rd_data_o  (rd_data_o),
  .illegal_o  (illegal_o),
  .auth_mask_o(auth_mask_o),
  .umask_q    (umask_q)
);

// File: tb/test_authmask_regfile.sv
module test_authmask_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic [9:0]  spr_num_i;
  logic        rd_en_i, wr_en_i, user_mode_i;
  logic [63:0] wr_data_i;
  logic [63:0] rd_data_o, auth_mask_o;
  logic        illegal_o;

  always #5 clk = ~clk;

  authmask_regfile i_authmask_regfile (
    .clk(clk), .rst(rst), .spr_num_i(spr_num_i), .rd_en_i(rd_en_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .user_mode_i(user_mode_i),
    .rd_data_o(rd_data_o), .illegal_o(illegal_o), .auth_mask_o(auth_mask_o)
  );

  typedef struct {
    string       req;
    logic [63:0] rd;
    logic        ill;
    logic [63:0] auth;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;
  logic [63:0] m_auth, m_umask;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: applies one access cycle and pushes the expected result.
  task automatic access(string req, logic [9:0] num, bit rd, bit wr,
                        logic [63:0] data, bit user);
    exp_t e;
    bit   usr_ok, prv_num, hit;
    @(negedge clk);
    spr_num_i = num; rd_en_i = rd; wr_en_i = wr; wr_data_i = data; user_mode_i = user;
    prv_num = (num == 10'd29) || (num == 10'h09D);
    hit     = (num == 10'd13) || prv_num;
    usr_ok  = !(user && prv_num);
    e.req = req;
    e.ill = (rd || wr) && !usr_ok;
    e.rd  = '0;
    if (rd && usr_ok && hit) e.rd = (num == 10'h09D) ? m_umask : m_auth;
    if (wr && usr_ok) begin
      if (num == 10'd13)        m_auth  = user ? (data & m_umask) : data;
      else if (num == 10'd29)   m_auth  = data;
      else if (num == 10'h09D)  m_umask = data;
    end
    e.auth = m_auth;
    sb.push_back(e);
  endtask

  task automatic idle(string req);
    access(req, 10'd0, 0, 0, 64'd0, 0);
  endtask

  // Monitor: compares each result just after the edge that produces it.
  always @(posedge clk) begin
    #1;
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.req, "rd_data", rd_data_o, e.rd);
      check(e.req, "illegal", {63'd0, illegal_o}, {63'd0, e.ill});
      check(e.req, "auth_mask", auth_mask_o, e.auth);
    end
  end

  initial begin
    rst = 1'b1; spr_num_i = '0; rd_en_i = 0; wr_en_i = 0; wr_data_i = '0; user_mode_i = 0;
    m_auth = '1; m_umask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R6 reset state at the ports
    check("R6", "auth_mask", auth_mask_o, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R6", "rd_data", rd_data_o, 64'd0);
    check("R6", "illegal", {63'd0, illegal_o}, 64'd0);

    access("R2", 10'd29, 1, 0, 0, 0);              // R2 R6 priv alias read -> all ones
    access("R5", 10'h09D, 1, 0, 0, 0);             // R5 R6 mask reads zero
    access("R1", 10'd13, 1, 0, 0, 1);              // R1 user read
    access("R3", 10'd13, 0, 1, 64'hFFFF_0000_1234_5678, 1); // R3 mask zero clears all
    access("R10", 10'd13, 1, 0, 0, 0);             // R10 R1 priv read of user alias
    access("R5", 10'h09D, 0, 1, 64'h00FF_00FF_0F0F_0F0F, 0);
    access("R5", 10'h09D, 1, 0, 0, 0);
    access("R3", 10'd13, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    access("R3", 10'd13, 0, 1, 64'h1234_5678_9ABC_DEF0, 1);
    access("R1", 10'd13, 1, 0, 0, 1);
    access("R4", 10'd29, 0, 1, 64'hDEAD_BEEF_CAFE_F00D, 0);
    access("R4", 10'd13, 0, 1, 64'hA5A5_5A5A_A5A5_5A5A, 0);
    access("R2", 10'd29, 1, 0, 0, 0);
    access("R8", 10'd29, 1, 1, 64'h0123_4567_89AB_CDEF, 0); // R8 old value returned
    access("R8", 10'd29, 1, 0, 0, 0);              // R8 new value visible
    access("R7", 10'd29, 1, 0, 0, 1);              // R7 user read of priv alias
    access("R7", 10'd29, 0, 1, 64'h0, 1);          // R7 user write blocked
    idle("R7");                                    // R7 flag lasts one cycle
    access("R7", 10'h09D, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    access("R7", 10'h09D, 1, 1, 64'h0, 1);
    access("R7", 10'h09D, 1, 0, 0, 0);             // R7 mask unchanged
    access("R9", 10'h010, 0, 1, 64'h5555, 0);      // R9 undecoded write
    access("R9", 10'h010, 1, 0, 0, 1);             // R9 undecoded read
    access("R9", 10'd29, 1, 0, 0, 0);              // R9 auth unchanged
    idle("R9");
    idle("R9");
    @(negedge clk);
    @(negedge clk);
    check("R10", "auth_mask hold", auth_mask_o, m_auth);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule